// File: doc/BRIEF.md
# Radix-4 Add-Compare-Select Array for a 64-State Trellis

This block is the metric-update core of a high-throughput Viterbi decoder for a rate-1/3 convolutional code with constraint length 7. It holds one path metric per trellis state, 64 of them, and updates all of them in the same clock. Each update covers two trellis stages, so one clock carries two decoded bits' worth of progress. For every state the block forms four candidates. Each candidate is the metric of one predecessor two stages back plus the two-step branch cost of the path from it. The block keeps the cheapest candidate and reports which of the four predecessors won as a 2-bit decision.

An upstream branch-metric unit supplies, for each of the two stages in a clock, a cost for each of the eight possible 3-bit coded symbols. The array maps those costs onto the 256 two-step transitions through the encoder's generator polynomials. The mapping is fixed at elaboration, so it costs only wiring. A downstream traceback unit stores the 64 decisions of each clock. It starts its walk from the best-state index, which the block also provides. A start-of-frame strobe seeds the metrics so that decoding begins from state 0. Metrics are 9 bits and wrap freely, because every comparison is made on the sign of the 9-bit difference.

Top module: `radix4_acs_array`

## Requirements
- R1: The 6-bit state holds the last six inputs, with bit 5 the newest. For a pair whose first input is a and second input is b, predecessor p leads to state {b, a, p[5:2]}. So the four predecessors of state s are p_j = ((s << 2) | j) mod 64 for j = 0..3. The decision reported for s is the j of the chosen predecessor, and it sits at `decisions[2s+1:2s]`.
- R2: A step's coded symbol is taken from the 7-bit encoder register {u, prev}, where u is the new input (bit 6) and prev is the 6-bit state. Code bit k equals the parity of the register ANDed with polynomial Gk, with defaults G0 = 133, G1 = 165 and G2 = 171 in octal. The symbol index is {c2, c1, c0}. The cost of symbol c is taken from bits [c*5 +: 5] of `bmFirst` for the first stage and of `bmSecond` for the second stage. The candidate cost adds both stage costs to the predecessor's metric.
- R3: On a valid pair, each state's new metric is the smallest of its four candidates.
- R4: When candidates are equal, the lowest predecessor index j wins.
- R5: Metrics are 9-bit and wrap modulo 512. Metric a is better than b when bit 8 of (a − b) mod 512 is set. Decisions stay correct after the metrics have wrapped many times.
- R6: After reset, and on a clock with `frameStart` high and `inValid` low, state 0 holds metric 0 and every other state holds 96.
- R7: On a clock with both `frameStart` and `inValid` high, the pair is processed from the seed metrics of R6 instead of the stored metrics.
- R8: On a clock with `inValid` low and `frameStart` low, the stored metrics do not change, whatever the branch inputs are.
- R9: `decValid` is high in the cycle after a clock that had `inValid` high, and low otherwise. `decisions` change only on those clocks and are all zero after reset.
- R10: `bestState` is the index of the state with the best stored metric, taken as the lowest index among equals. It refers to the same stage as the current `decisions`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Branch costs for a stage pair are present |
| frameStart | input | 1 | Seeds the metrics for a new frame |
| bmFirst | input | 40 | Eight 5-bit symbol costs for the first stage |
| bmSecond | input | 40 | Eight 5-bit symbol costs for the second stage |
| decValid | output | 1 | Decisions belong to the last valid pair |
| decisions | output | 128 | 2-bit winning predecessor index for each state |
| bestState | output | 6 | State with the best current metric |

## Verification
The bench drives the array with all-zero costs from a fresh seed. There almost every candidate ties, so a tie-break that favours any index other than the lowest gives wrong decisions at once. A long run with large costs pushes the metrics through many 512 wraps. A magnitude compare in place of the sign-of-difference rule then inverts decisions after the first wrap. Idle clocks with random costs on the bus, and start-of-frame alone or together with a valid pair, test the hold and seed behaviour. If the seed is ignored, or the stored metrics are used on a start-of-frame pair, decisions and the best state diverge from the bench's unbounded-integer model in the next clock.

// File: rtl/r4acs_pkg.sv
package r4acs_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic advance;   // run the ACS update this clock
    logic useSeed;   // take seed metrics as ACS source
    logic loadSeed;  // overwrite stored metrics with the seed
  } acsStrobes_t;

  localparam int SYM_BITS = 3;
  localparam int NUM_SYMS = 1 << SYM_BITS;

  function automatic int parityOf(input int v);
    int p;
    p = 0;
    for (int i = 0; i < 32; i++) p = p ^ ((v >> i) & 1);
    return p;
  endfunction

  // coded symbol index {c2,c1,c0} for encoder register value r
  function automatic int symOf(input int r, input int g0, input int g1, input int g2);
    return parityOf(r & g0) | (parityOf(r & g1) << 1) | (parityOf(r & g2) << 2);
  endfunction

endpackage

// File: rtl/r4acs_ctrl.sv
module r4acs_ctrl
  import r4acs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inValid,
  input  logic        frameStart,
  output acsStrobes_t strb,
  output logic        decValid
);

  always_comb begin
    strb.advance  = inValid;
    strb.useSeed  = frameStart;
    strb.loadSeed = frameStart && !inValid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) decValid <= 1'b0;
    else        decValid <= inValid;
  end

endmodule

// File: rtl/r4acs_unit.sv
module r4acs_unit #(
  parameter int PMW = 9,
  parameter int BRW = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [PMW-1:0] predMetric [4],
  input  logic [BRW-1:0] branchCost [4],
  output logic [PMW-1:0] newMetric,
  output logic [1:0]     decision
);

  logic [PMW-1:0] cand [4];
  logic           loPick;
  logic           hiPick;
  logic [1:0]     loIdx;
  logic [1:0]     hiIdx;

  function automatic logic better(input logic [PMW-1:0] a, input logic [PMW-1:0] b);
    logic [PMW-1:0] d;
    d = a - b;
    return d[PMW-1];
  endfunction

  for (genvar j = 0; j < 4; j++) begin : g_cand
    assign cand[j] = predMetric[j] + PMW'(branchCost[j]);
  end

  // two-level tournament, the lower index keeps ties
  always_comb begin
    loPick = better(cand[1], cand[0]);
    hiPick = better(cand[3], cand[2]);
    loIdx  = loPick ? 2'd1 : 2'd0;
    hiIdx  = hiPick ? 2'd3 : 2'd2;
    if (better(cand[hiIdx], cand[loIdx])) decision = hiIdx;
    else                                  decision = loIdx;
    newMetric = cand[decision];
  end

  for (genvar k = 0; k < 4; k++) begin : g_chk
    AST_SELECT_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      !better(cand[k], newMetric)); // R3
    AST_TIE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (k < int'(decision)) |-> better(newMetric, cand[k])); // R4
  end

endmodule

// File: rtl/r4acs_datapath.sv
module r4acs_datapath
  import r4acs_pkg::*;
#(
  parameter int K           = 7,
  parameter int PMW         = 9,
  parameter int BMW         = 5,
  parameter int INIT_OFFSET = 96,
  parameter int G0          = 'o133,
  parameter int G1          = 'o165,
  parameter int G2          = 'o171,
  localparam int SW         = K - 1,
  localparam int STATES     = 1 << SW,
  localparam int BRW        = BMW + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  acsStrobes_t             strb,
  input  logic [NUM_SYMS*BMW-1:0] bmFirst,
  input  logic [NUM_SYMS*BMW-1:0] bmSecond,
  output logic [2*STATES-1:0]     decisions,
  output logic [SW-1:0]           bestState
);

  localparam logic [PMW-1:0] SEED_OFF = PMW'(INIT_OFFSET);

  logic [PMW-1:0] pmReg   [STATES];
  logic [PMW-1:0] seedVal [STATES];
  logic [PMW-1:0] srcVal  [STATES];
  logic [PMW-1:0] nextVal [STATES];
  logic [1:0]     nextDec [STATES];
  logic [BMW-1:0] costA   [NUM_SYMS];
  logic [BMW-1:0] costB   [NUM_SYMS];
  logic [PMW-1:0] redVal  [STATES];
  logic [SW-1:0]  redIdx  [STATES];

  function automatic logic better(input logic [PMW-1:0] a, input logic [PMW-1:0] b);
    logic [PMW-1:0] d;
    d = a - b;
    return d[PMW-1];
  endfunction

  for (genvar c = 0; c < NUM_SYMS; c++) begin : g_cost
    assign costA[c] = bmFirst[c*BMW +: BMW];
    assign costB[c] = bmSecond[c*BMW +: BMW];
  end

  for (genvar s = 0; s < STATES; s++) begin : g_src
    assign seedVal[s] = (s == 0) ? '0 : SEED_OFF;
    assign srcVal[s]  = strb.useSeed ? seedVal[s] : pmReg[s];
  end

  // per-state wiring of predecessors and two-stage branch costs
  for (genvar s = 0; s < STATES; s++) begin : g_state
    logic [PMW-1:0] predM [4];
    logic [BRW-1:0] brSum [4];
    for (genvar j = 0; j < 4; j++) begin : g_pred
      localparam int P   = ((s << 2) | j) % STATES;
      localparam int UA  = (s >> (SW - 2)) & 1;
      localparam int UB  = (s >> (SW - 1)) & 1;
      localparam int MID = (UA << (SW - 1)) | (P >> 1);
      localparam int CW1 = symOf((UA << SW) | P, G0, G1, G2);
      localparam int CW2 = symOf((UB << SW) | MID, G0, G1, G2);
      assign predM[j] = srcVal[P];
      assign brSum[j] = {1'b0, costA[CW1]} + {1'b0, costB[CW2]};
    end
    r4acs_unit #(.PMW(PMW), .BRW(BRW)) u_acs (
      .clk        (clk),
      .rst_n      (rst_n),
      .predMetric (predM),
      .branchCost (brSum),
      .newMetric  (nextVal[s]),
      .decision   (nextDec[s])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STATES; s++) pmReg[s] <= (s == 0) ? '0 : SEED_OFF;
      decisions <= '0;
    end else if (strb.loadSeed) begin
      for (int s = 0; s < STATES; s++) pmReg[s] <= seedVal[s];
    end else if (strb.advance) begin
      for (int s = 0; s < STATES; s++) begin
        pmReg[s]            <= nextVal[s];
        decisions[2*s +: 2] <= nextDec[s];
      end
    end
  end

  // halving reduction tree; lower index keeps ties
  always_comb begin
    for (int i = 0; i < STATES; i++) begin
      redVal[i] = pmReg[i];
      redIdx[i] = SW'(i);
    end
    for (int w = STATES / 2; w > 0; w = w / 2) begin
      for (int i = 0; i < w; i++) begin
        if (better(redVal[2*i+1], redVal[2*i])) begin
          redVal[i] = redVal[2*i+1];
          redIdx[i] = redIdx[2*i+1];
        end else begin
          redVal[i] = redVal[2*i];
          redIdx[i] = redIdx[2*i];
        end
      end
    end
  end

  assign bestState = redIdx[0];

  for (genvar s = 0; s < STATES; s++) begin : g_chk
    AST_BEST_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      !better(pmReg[s], pmReg[bestState])); // R10
    AST_BEST_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (s < int'(bestState)) |-> better(pmReg[bestState], pmReg[s])); // R10
    AST_HOLD_METRIC: assert property (@(posedge clk) disable iff (!rst_n)
      (!strb.advance && !strb.loadSeed) |=> $stable(pmReg[s])); // R8
  end

  AST_SEED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    strb.loadSeed |=> (pmReg[0] == '0) && (pmReg[STATES-1] == SEED_OFF)); // R6
  AST_DEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.advance |=> $stable(decisions)); // R9

endmodule

// File: rtl/radix4_acs_array.sv
module radix4_acs_array #(
  parameter int K           = 7,
  parameter int PMW         = 9,
  parameter int BMW         = 5,
  parameter int INIT_OFFSET = 96,
  parameter int G0          = 'o133,
  parameter int G1          = 'o165,
  parameter int G2          = 'o171,
  localparam int SW         = K - 1,
  localparam int STATES     = 1 << SW,
  localparam int BUSW       = r4acs_pkg::NUM_SYMS * BMW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                inValid,
  input  logic                frameStart,
  input  logic [BUSW-1:0]     bmFirst,
  input  logic [BUSW-1:0]     bmSecond,
  output logic                decValid,
  output logic [2*STATES-1:0] decisions,
  output logic [SW-1:0]       bestState
);

  r4acs_pkg::acsStrobes_t strb;

  r4acs_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .inValid    (inValid),
    .frameStart (frameStart),
    .strb       (strb),
    .decValid   (decValid)
  );

  r4acs_datapath #(
    .K(K), .PMW(PMW), .BMW(BMW), .INIT_OFFSET(INIT_OFFSET),
    .G0(G0), .G1(G1), .G2(G2)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .bmFirst   (bmFirst),
    .bmSecond  (bmSecond),
    .decisions (decisions),
    .bestState (bestState)
  );

endmodule

// File: tb/radix4_acs_array_test.sv
module radix4_acs_array_test;

  localparam int NS = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         inValid = 1'b0;
  logic         frameStart = 1'b0;
  logic [39:0]  bmFirst = '0;
  logic [39:0]  bmSecond = '0;
  logic         decValid;
  logic [127:0] decisions;
  logic [5:0]   bestState;

  int errors = 0;
  int checks = 0;
  longint pm [NS];
  logic [127:0] expDec = '0;
  int costA [8];
  int costB [8];

  always #10 clk = ~clk;

  radix4_acs_array uut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .frameStart(frameStart),
    .bmFirst(bmFirst), .bmSecond(bmSecond), .decValid(decValid),
    .decisions(decisions), .bestState(bestState)
  );

  function automatic int par(input int v);
    int p = 0;
    for (int i = 0; i < 7; i++) p ^= (v >> i) & 1;
    return p;
  endfunction

  function automatic int sym(input int u, input int prev);
    int r = (u << 6) | prev;
    return par(r & 'o133) | (par(r & 'o165) << 1) | (par(r & 'o171) << 2);
  endfunction

  function automatic int bestOf();
    int b = 0;
    for (int s = 1; s < NS; s++) if (pm[s] < pm[b]) b = s;
    return b;
  endfunction

  task automatic seedModel();
    for (int s = 0; s < NS; s++) pm[s] = (s == 0) ? 0 : 96;
  endtask

  task automatic advanceModel();
    longint nx [NS];
    for (int s = 0; s < NS; s++) begin
      int a = (s >> 4) & 1;
      int b = (s >> 5) & 1;
      int win = 0;
      longint bestC = 0;
      for (int j = 0; j < 4; j++) begin
        int p = ((s << 2) | j) % NS;
        int mid = (a << 5) | (p >> 1);
        longint c = pm[p] + costA[sym(a, p)] + costB[sym(b, mid)];
        if (j == 0 || c < bestC) begin bestC = c; win = j; end
      end
      nx[s] = bestC;
      expDec[2*s +: 2] = 2'(win);
    end
    for (int s = 0; s < NS; s++) pm[s] = nx[s];
  endtask

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, update model, check after posedge
  task automatic step(input bit v, input bit f, input string req);
    for (int c = 0; c < 8; c++) begin
      bmFirst[c*5 +: 5]  = 5'(costA[c]);
      bmSecond[c*5 +: 5] = 5'(costB[c]);
    end
    inValid = v;
    frameStart = f;
    if (f) seedModel();
    if (v) advanceModel();
    @(posedge clk);
    @(negedge clk);
    check({req, " R9 decValid"}, 128'(decValid), 128'(v));
    check({req, " decisions"}, decisions, expDec);
    check({req, " R10 bestState"}, 128'(bestState), 128'(bestOf()));
  endtask

  task automatic setCosts(input int lo, input int hi);
    for (int c = 0; c < 8; c++) begin
      costA[c] = $urandom_range(hi, lo);
      costB[c] = $urandom_range(hi, lo);
    end
  endtask

  task automatic t_reset();
    seedModel();
    check("R6 reset bestState", 128'(bestState), 128'(0));
    check("R9 reset decValid", 128'(decValid), 128'(0));
    check("R9 reset decisions", decisions, '0);
  endtask

  task automatic t_zero_costs();
    setCosts(0, 0);
    step(1'b0, 1'b1, "R6 seed only");
    step(1'b1, 1'b0, "R4 zero costs 1");
    step(1'b1, 1'b0, "R4 zero costs 2");
  endtask

  task automatic t_single_path();
    for (int c = 0; c < 8; c++) begin
      costA[c] = (c == 0) ? 0 : 21;
      costB[c] = (c == 7) ? 0 : 21;
    end
    step(1'b0, 1'b1, "R6 seed");
    for (int n = 0; n < 6; n++) step(1'b1, 1'b0, "R1 R2 single path");
  endtask

  task automatic t_random_frame();
    setCosts(0, 21);
    step(1'b1, 1'b1, "R7 start with pair");
    for (int n = 0; n < 40; n++) begin
      setCosts(0, 21);
      step(1'b1, 1'b0, "R2 R3 random");
    end
  endtask

  task automatic t_hold();
    for (int n = 0; n < 5; n++) begin
      setCosts(0, 21);
      step(1'b0, 1'b0, "R8 idle");
    end
    for (int n = 0; n < 5; n++) begin
      setCosts(0, 21);
      step(1'b1, 1'b0, "R8 after idle");
    end
  endtask

  task automatic t_restart();
    setCosts(0, 21);
    step(1'b0, 1'b1, "R6 mid-stream seed");
    for (int n = 0; n < 4; n++) begin
      setCosts(0, 21);
      step(1'b1, 1'b0, "R6 after seed");
    end
    setCosts(0, 21);
    step(1'b1, 1'b1, "R7 mid-stream start");
    setCosts(0, 21);
    step(1'b1, 1'b0, "R7 after start");
  endtask

  task automatic t_wrap();
    for (int n = 0; n < 400; n++) begin
      setCosts(10, 21);
      step(1'b1, 1'b0, "R5 wrapped metrics");
    end
    checks++;
    if (pm[bestOf()] < 2048) begin
      errors++;
      $display("FAIL R5 metric span actual=%0d expected>=%0d", pm[bestOf()], 2048);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_zero_costs();
    t_single_path();
    t_random_frame();
    t_hold();
    t_restart();
    t_wrap();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule